// File: doc/BRIEF.md
# Embedded-Clock Serial Symbol Framer

This block turns a 21-bit parallel pixel word into a 28-bit serial symbol on a single-bit line, one symbol per pixel period. Each symbol opens with a clock marker that is always 1 and closes with a marker that is always 0, so a receiver can recover the pixel clock from the stream. Between the markers sit the scrambled payload, an inversion flag and four check bits. The payload is scrambled with a per-symbol keystream, and is inverted whenever that pulls the accumulated line disparity toward zero, so the line stays DC-balanced and can be AC coupled.

The block runs on the bit clock. A bit-rate enable `bit_en` pulses 28 times per pixel period and advances the shifter once per pulse. The pixel clock comes in as a level that is synchronous to the bit clock. A configuration input picks whether its rising or its falling edge captures the word. A power-down input parks the line at a static high level and restarts the link.

A three-state machine sequences the link. `ST_OFF` drives the line high. It leaves for `ST_WAIT` once power-down is released. `ST_WAIT` also drives the line high, and moves to `ST_SEND` on the first bit enable after a word has been captured. `ST_SEND` keeps shifting symbols back to back. Every state returns to `ST_OFF` when power-down is sampled high.

Top module: `emb_clk_framer`

## Requirements
- R1: A symbol is 28 bits sent MSB first (bit 27 first), one bit per `bit_en` pulse. Bit 27 is the high marker, bits 26:6 hold the 21-bit line payload (payload bit 0 at symbol bit 6), bit 5 is the inversion flag, bits 4:1 are check bits and bit 0 is the low marker.
- R2: Symbol bit 27 is always 1 and symbol bit 0 is always 0.
- R3: The scrambled word is the captured word XOR a keystream k, where k[i] = L[i mod 16] and L is a 16-bit LFSR. The LFSR steps once per symbol as L' = {L[14:0], L[15]^L[13]^L[12]^L[10]}. The first symbol after link start uses the seed `SEED` (default 16'hACE1).
- R4: With `edge_sel` = 1 the word present at a rising edge of `pix_clk` is captured. With `edge_sel` = 0 the word present at a falling edge is captured. The other edge has no effect.
- R5: After reset, and from the cycle after `pwr_dn` is sampled high, `ser_out` is 1 and stays 1 while `pwr_dn` is high. Releasing `pwr_dn` restarts the link: the LFSR returns to the seed and the running disparity to 0.
- R6: Let d0 be (2 x ones in the scrambled word) - 22, the symbol disparity if it is not inverted. When the running disparity RD and d0 are both nonzero and share a sign, the payload is inverted, bit 5 is 1 and RD becomes RD - d0. Otherwise bit 5 is 0 and RD becomes RD + d0. |RD| never exceeds 22.
- R7: Bits 4:1 are {pe, ~pe, po, ~po}. pe is the XOR of the line payload bits at even indices and po is the XOR of those at odd indices, so the check field carries zero disparity.
- R8: The shifter and the line change only on a `bit_en` pulse. A new symbol is loaded only when the previous one has sent its last bit, or on the first `bit_en` after the first capture following link start. With a pixel period of 28 `bit_en` pulses, every captured word appears in exactly one symbol, in capture order.
- R9: After link start and before the first symbol, `ser_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down; parks the line high and restarts the link |
| edge_sel | input | 1 | 1: capture on rising pixel clock edge, 0: on falling edge |
| pix_clk | input | 1 | Pixel clock level, synchronous to `clk` |
| pix_data | input | PAY_W (21) | Parallel pixel word |
| bit_en | input | 1 | Bit-rate enable, 28 pulses per pixel period |
| ser_out | output | 1 | Serial symbol stream |

## Verification
The bench builds the block with its defaults: a 21-bit payload and seed 16'hACE1. It runs every combination of capture edge with enable spacings of one and two clock cycles. Each run starts the link fresh, so both the reseed and the gaps between enables are covered. In every run the word at the rising edge differs from the word at the falling edge. The word sequence starts with each single-bit word, then all zeros, all ones and a spread of computed values, which drives the disparity accumulator through both signs and both inversion choices. Every received symbol is rebuilt from the requirements and decoded back to the driven word. Each run ends with a power-down in the middle of a symbol.

// File: rtl/efr_pkg.sv
package efr_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } link_state_t;

    localparam int MARK_BITS = 2;
    localparam int CHK_BITS  = 5;
    localparam int LFSR_W    = 16;

endpackage

// File: rtl/efr_capture.sv
module efr_capture #(
    parameter int PAY_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             edge_sel,
    input  logic             pix_clk,
    input  logic [PAY_W-1:0] pix_data,
    output logic [PAY_W-1:0] hold_word,
    output logic             hold_vld
);

    logic pix_q;
    logic rise;
    logic fall;
    logic take;

    always_comb begin
        rise = pix_clk & ~pix_q;
        fall = ~pix_clk & pix_q;
        take = enable & (edge_sel ? rise : fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q     <= 1'b0;
            hold_word <= '0;
            hold_vld  <= 1'b0;
        end else begin
            pix_q <= pix_clk;
            if (!enable) begin
                hold_vld <= 1'b0;
            end else if (take) begin
                hold_word <= pix_data;
                hold_vld  <= 1'b1;
            end
        end
    end

    AST_HOLD_ON_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(edge_sel ? (pix_clk && !pix_q) : (!pix_clk && pix_q))) |=> $stable(hold_word)); // R4

endmodule

// File: rtl/efr_encoder.sv
module efr_encoder
    import efr_pkg::*;
#(
    parameter int          PAY_W = 21,
    parameter logic [15:0] SEED  = 16'hACE1,
    localparam int         SYM_W = PAY_W + MARK_BITS + CHK_BITS,
    localparam int         DW    = $clog2(2 * PAY_W + 4) + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             advance,
    input  logic [PAY_W-1:0] data,
    output logic [SYM_W-1:0] sym
);

    logic [LFSR_W-1:0]   lfsr_q;
    logic [LFSR_W-1:0]   lfsr_nx;
    logic signed [DW-1:0] rd_q;
    logic signed [DW-1:0] rd_nx;
    logic [PAY_W-1:0]    keystr;
    logic [PAY_W-1:0]    scr;
    logic [PAY_W-1:0]    pay;
    logic                inv;
    logic                par_e;
    logic                par_o;

    always_comb begin
        int ones;
        int d0;
        int rdi;
        for (int i = 0; i < PAY_W; i++) begin
            keystr[i] = lfsr_q[i % LFSR_W];
        end
        scr  = data ^ keystr;
        ones = 0;
        for (int i = 0; i < PAY_W; i++) begin
            ones = ones + int'(scr[i]);
        end
        d0  = 2 * ones - PAY_W - 1;
        rdi = int'(rd_q);
        inv = ((rdi > 0) && (d0 > 0)) || ((rdi < 0) && (d0 < 0));
        pay = inv ? ~scr : scr;
        par_e = 1'b0;
        par_o = 1'b0;
        for (int i = 0; i < PAY_W; i++) begin
            if ((i % 2) == 0) begin
                par_e = par_e ^ pay[i];
            end else begin
                par_o = par_o ^ pay[i];
            end
        end
        sym     = {1'b1, pay, inv, par_e, ~par_e, par_o, ~par_o, 1'b0};
        rd_nx   = inv ? DW'(rdi - d0) : DW'(rdi + d0);
        lfsr_nx = {lfsr_q[LFSR_W-2:0],
                   lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            rd_q   <= '0;
        end else if (restart) begin
            lfsr_q <= SEED;
            rd_q   <= '0;
        end else if (advance) begin
            lfsr_q <= lfsr_nx;
            rd_q   <= rd_nx;
        end
    end

    AST_DISP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_q) <= PAY_W + 1) && (int'(rd_q) >= -(PAY_W + 1))); // R6

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R3

    AST_LFSR_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !restart) |=> (lfsr_q != $past(lfsr_q))); // R3

    AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (lfsr_q == SEED) && (rd_q == '0)); // R5

endmodule

// File: rtl/emb_clk_framer.sv
module emb_clk_framer
    import efr_pkg::*;
#(
    parameter int          PAY_W = 21,
    parameter logic [15:0] SEED  = 16'hACE1,
    localparam int         SYM_W = PAY_W + MARK_BITS + CHK_BITS,
    localparam int         CW    = $clog2(SYM_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             edge_sel,
    input  logic             pix_clk,
    input  logic [PAY_W-1:0] pix_data,
    input  logic             bit_en,
    output logic             ser_out
);

    localparam logic [CW-1:0] LAST_BIT = CW'(SYM_W - 1);

    link_state_t      st_q;
    link_state_t      st_nx;
    logic [SYM_W-1:0] shreg;
    logic [CW-1:0]    bit_cnt;
    logic [PAY_W-1:0] hold_word;
    logic             hold_vld;
    logic [SYM_W-1:0] sym;
    logic             load;
    logic             cap_en;
    logic             restart;

    efr_capture #(.PAY_W(PAY_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cap_en),
        .edge_sel  (edge_sel),
        .pix_clk   (pix_clk),
        .pix_data  (pix_data),
        .hold_word (hold_word),
        .hold_vld  (hold_vld)
    );

    efr_encoder #(.PAY_W(PAY_W), .SEED(SEED)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .advance (load),
        .data    (hold_word),
        .sym     (sym)
    );

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_OFF:  if (!pwr_dn) st_nx = ST_WAIT;
            ST_WAIT: begin
                if (pwr_dn) st_nx = ST_OFF;
                else if (bit_en && hold_vld) st_nx = ST_SEND;
            end
            ST_SEND: if (pwr_dn) st_nx = ST_OFF;
            default: st_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_nx;
    end

    always_comb begin
        cap_en  = (st_q != ST_OFF) && !pwr_dn;
        restart = (st_q == ST_OFF);
        load    = !pwr_dn && bit_en &&
                  (((st_q == ST_WAIT) && hold_vld) ||
                   ((st_q == ST_SEND) && (bit_cnt == LAST_BIT)));
        unique case (st_q)
            ST_SEND: ser_out = shreg[SYM_W-1];
            default: ser_out = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '1;
            bit_cnt <= '0;
        end else if (st_q == ST_OFF) begin
            shreg   <= '1;
            bit_cnt <= '0;
        end else if (load) begin
            shreg   <= sym;
            bit_cnt <= '0;
        end else if ((st_q == ST_SEND) && bit_en) begin
            shreg   <= {shreg[SYM_W-2:0], 1'b0};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    AST_MARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SEND) && (bit_cnt == '0)) |-> ser_out); // R2

    AST_MARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SEND) && (bit_cnt == LAST_BIT)) |-> !ser_out); // R2

    AST_PD_STATIC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> ser_out); // R5

    AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_SEND) && !bit_en && !pwr_dn) |=> ($stable(bit_cnt) && $stable(ser_out))); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) < SYM_W); // R1

endmodule

// File: tb/tb_emb_clk_framer.sv
module tb_emb_clk_framer;

    localparam int          PW   = 21;
    localparam int          SW   = 28;
    localparam logic [15:0] SEED = 16'hACE1;
    localparam int          NPER = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_dn = 1'b1;
    logic          edge_sel = 1'b1;
    logic          pix_clk = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic          bit_en = 1'b0;
    logic          ser_out;

    always #2 clk = ~clk;

    emb_clk_framer #(.PAY_W(PW), .SEED(SEED)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .edge_sel (edge_sel),
        .pix_clk  (pix_clk),
        .pix_data (pix_data),
        .bit_en   (bit_en),
        .ser_out  (ser_out)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0]   m_lfsr;
    int            m_rd;
    int            m_idx;
    bit            collecting;
    int            nbits;
    logic [SW-1:0] rx;
    logic          prev_out;
    logic          pc_prev = 1'b0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pat(input int k);
        if (k < PW)       return PW'(1) << k;
        else if (k == PW) return '0;
        else if (k == PW + 1) return '1;
        else              return PW'((k * 32'h0009_E3B5) ^ (k << 7));
    endfunction

    function automatic logic [PW-1:0] rise_word(input int k);
        return pat(k);
    endfunction

    function automatic logic [PW-1:0] fall_word(input int k);
        return ~pat(k + 3);
    endfunction

    task automatic check_symbol();
        logic [PW-1:0] d;
        logic [PW-1:0] ks;
        logic [PW-1:0] scr;
        logic [PW-1:0] pay;
        logic [PW-1:0] dec;
        logic [SW-1:0] exp_sym;
        logic          pe;
        logic          po;
        logic          rpe;
        logic          rpo;
        bit            inv;
        int            ones;
        int            d0;
        d = edge_sel ? rise_word(m_idx) : fall_word(m_idx);
        for (int i = 0; i < PW; i++) ks[i] = m_lfsr[i % 16];
        scr  = d ^ ks;
        ones = 0;
        for (int i = 0; i < PW; i++) ones += int'(scr[i]);
        d0  = 2 * ones - PW - 1;
        inv = ((m_rd > 0) && (d0 > 0)) || ((m_rd < 0) && (d0 < 0));
        pay = inv ? ~scr : scr;
        pe = 1'b0; po = 1'b0; rpe = 1'b0; rpo = 1'b0;
        for (int i = 0; i < PW; i++) begin
            if ((i % 2) == 0) begin pe ^= pay[i]; rpe ^= rx[6+i]; end
            else              begin po ^= pay[i]; rpo ^= rx[6+i]; end
        end
        exp_sym = {1'b1, pay, inv, pe, ~pe, po, ~po, 1'b0};
        check(rx[SW-1] == 1'b1, "R2 high marker", longint'(rx[SW-1]), 1);
        check(rx[0] == 1'b0, "R2 low marker", longint'(rx[0]), 0);
        check(rx[4:1] == {rpe, ~rpe, rpo, ~rpo}, "R7 check bits", longint'(rx[4:1]),
              longint'({rpe, ~rpe, rpo, ~rpo}));
        check(rx[5] == inv, "R6 inversion flag", longint'(rx[5]), longint'(inv));
        dec = rx[26:6] ^ {PW{rx[5]}} ^ ks;
        check(dec == d, "R3 R4 descrambled word", longint'(dec), longint'(d));
        check(rx == exp_sym, "R1 whole symbol", longint'(rx), longint'(exp_sym));
        m_rd   = inv ? (m_rd - d0) : (m_rd + d0);
        m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        m_idx++;
    endtask

    task automatic step(input bit be, input bit pc, input logic [PW-1:0] d);
        bit cap;
        bit_en   = be;
        pix_clk  = pc;
        pix_data = d;
        @(posedge clk);
        #1;
        if (collecting) begin
            if (be) begin
                rx = {rx[SW-2:0], ser_out};
                nbits++;
                if (nbits == SW) begin
                    check_symbol();
                    nbits = 0;
                end
            end else begin
                check(ser_out == prev_out, "R8 line held between enables",
                      longint'(ser_out), longint'(prev_out));
            end
        end else if (!pwr_dn) begin
            check(ser_out == 1'b1, "R9 idle high before first symbol", longint'(ser_out), 1);
        end
        prev_out = ser_out;
        cap = edge_sel ? (pc && !pc_prev) : (!pc && pc_prev);
        if (cap && !pwr_dn && !collecting) begin
            collecting = 1'b1;
            nbits      = 0;
        end
        pc_prev = pc;
    endtask

    task automatic run_config(input bit edge_m, input int div);
        int per;
        logic [PW-1:0] d;
        per      = SW * div;
        edge_sel = edge_m;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, '0);
            check(ser_out == 1'b1, "R5 high while powered down", longint'(ser_out), 1);
        end
        m_lfsr     = SEED;
        m_rd       = 0;
        m_idx      = 0;
        collecting = 1'b0;
        nbits      = 0;
        pwr_dn     = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, rise_word(0));
        for (int k = 0; k <= NPER; k++) begin
            for (int s = 0; s < per; s++) begin
                if (s == 0)             d = rise_word(k);
                else if (s <= per / 2)  d = fall_word(k);
                else                    d = rise_word(k + 1);
                step((s % div) == 0, s < per / 2, d);
            end
        end
        check(m_idx == NPER, "R8 one symbol per captured word", longint'(m_idx), NPER);
        collecting = 1'b0;
        pwr_dn     = 1'b1;
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 1'b0, '0);
            check(ser_out == 1'b1, "R5 power-down mid-symbol", longint'(ser_out), 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(ser_out == 1'b1, "R5 reset state high", longint'(ser_out), 1);
        rst_n = 1'b1;
        run_config(1'b1, 1);
        run_config(1'b0, 1);
        run_config(1'b1, 2);
        run_config(1'b0, 2);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual %0d cycles expected completion", 200000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule